// File: doc/BRIEF.md
# 64-bit Integer Execution Unit with Word Operations

This block performs the register-register and register-immediate integer operations of a 64-bit core: add, subtract, set-less-than (signed and unsigned), the three bitwise operations and the three shifts. Add, subtract and the shifts also have a 32-bit word form. A word form works on the low half of the operands and sign-extends its 32-bit result back to 64 bits. The caller supplies both operands, with the second one already chosen as either a register value or a sign-extended immediate, plus a 4-bit operation code and a word flag.

Inside, a decoder turns the operation code into a control bundle. That bundle steers three datapath units: a shared add/compare unit, a staged barrel shifter and a bitwise unit. One output register, cleared by an active-low reset, captures the selected result, so each result appears one clock after its operands.

There are no named states and no transitions. The only storage is the result register. Its two conditions are "cleared", held while `rst_n` is low, and "loaded", taken on every rising edge with `rst_n` high.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, the result register is cleared to zero on every rising clock edge.
- R2: The `result` port shows the outcome for the operands, `op_sel` and `word_mode` sampled at the most recent rising edge. A new input does not show on `result` before that edge.
- R3: Add (code 0) and subtract (code 1) wrap modulo 2^64 when `word_mode` is 0. There is no overflow indication.
- R4: With `word_mode` 0, the shift amount is `op_b[5:0]`. Shift left (code 2) and logical right (code 6) fill vacated bits with zeros. Arithmetic right (code 7) fills vacated bits with `op_a[63]`.
- R5: With `word_mode` 1, the shift amount is `op_b[4:0]`. Word right shifts act on `op_a[31:0]` only. The logical form fills from bit 31 downward with zeros, and the arithmetic form fills with `op_a[31]`.
- R6: With `word_mode` 1, add, subtract and the three shifts form a 32-bit result. Its bit 31 is copied into `result[63:32]`.
- R7: Set-less-than produces 1 when `op_a` is below `op_b` and 0 otherwise, in `result[0]` with all other bits zero. Code 3 compares as two's-complement signed values. Code 4 compares as unsigned values.
- R8: XOR (code 5), OR (code 8) and AND (code 9) act bit by bit on all 64 bits. For these and for both compares, `word_mode` has no effect.
- R9: Operation codes 10 through 15 are undefined and produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; result captured on the rising edge |
| rst_n | input | 1 | Active-low synchronous clear of the result register |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand: register value or sign-extended immediate; the low bits give the shift amount |
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and) |
| word_mode | input | 1 | Selects the 32-bit word form of add, sub and the shifts |
| result | output | 64 | Registered 64-bit result |

## Verification
The only state is the output register, so any fault in decoding, shift-amount masking, fill selection or word sign extension shows on `result` at the first rising edge after the faulty operands are applied. It is gone again one edge later, when new operands arrive. The checks therefore look at every operation on the cycle after it is applied. Most wrong-fill or wrong-mask faults show only as a corrupted upper half or a wrong low bit, so many checks use operands with bit 31 or bit 63 set, shift amounts of 0, 31, 32 and 63, and second operands whose upper bits must be ignored. A result register that misses its clear shows as a non-zero value during reset.

// File: rtl/iex_pkg.sv
`timescale 1ns/1ps
package iex_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SLT  = 4'd3,
        OP_SLTU = 4'd4,
        OP_XOR  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_OR   = 4'd8,
        OP_AND  = 4'd9
    } iex_op_e;

    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_ARITH,
        UNIT_CMP,
        UNIT_SHIFT,
        UNIT_LOGIC
    } iex_unit_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RLOG,
        SH_RARI
    } iex_shift_e;

    typedef enum logic [1:0] {
        LG_XOR,
        LG_OR,
        LG_AND
    } iex_logic_e;

    typedef struct packed {
        iex_unit_e  unit;
        logic       sub;
        logic       cmp_uns;
        iex_shift_e sh;
        iex_logic_e lg;
        logic       word;
    } iex_ctrl_t;

endpackage

// File: rtl/iex_decode.sv
`timescale 1ns/1ps
module iex_decode
    import iex_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    input  logic            word_mode,
    output iex_ctrl_t       ctrl
);

    iex_op_e op;

    assign op = iex_op_e'(op_sel);

    always_comb begin
        ctrl         = '0;
        ctrl.unit    = UNIT_NONE;
        ctrl.sh      = SH_LEFT;
        ctrl.lg      = LG_XOR;
        unique case (op)
            OP_ADD:  ctrl.unit = UNIT_ARITH;
            OP_SUB: begin
                ctrl.unit = UNIT_ARITH;
                ctrl.sub  = 1'b1;
            end
            OP_SLT: begin
                ctrl.unit = UNIT_CMP;
                ctrl.sub  = 1'b1;
            end
            OP_SLTU: begin
                ctrl.unit    = UNIT_CMP;
                ctrl.sub     = 1'b1;
                ctrl.cmp_uns = 1'b1;
            end
            OP_SLL: begin
                ctrl.unit = UNIT_SHIFT;
                ctrl.sh   = SH_LEFT;
            end
            OP_SRL: begin
                ctrl.unit = UNIT_SHIFT;
                ctrl.sh   = SH_RLOG;
            end
            OP_SRA: begin
                ctrl.unit = UNIT_SHIFT;
                ctrl.sh   = SH_RARI;
            end
            OP_XOR: begin
                ctrl.unit = UNIT_LOGIC;
                ctrl.lg   = LG_XOR;
            end
            OP_OR: begin
                ctrl.unit = UNIT_LOGIC;
                ctrl.lg   = LG_OR;
            end
            OP_AND: begin
                ctrl.unit = UNIT_LOGIC;
                ctrl.lg   = LG_AND;
            end
            default: ctrl.unit = UNIT_NONE;
        endcase
        // word form only exists for add, sub and shifts
        ctrl.word = word_mode &
                    ((ctrl.unit == UNIT_ARITH) || (ctrl.unit == UNIT_SHIFT));
    end

endmodule

// File: rtl/iex_addsub.sv
`timescale 1ns/1ps
module iex_addsub #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    input  logic            cmp_uns,
    input  logic            word,
    output logic [XLEN-1:0] sum,
    output logic            lt
);

    localparam int HALF = XLEN / 2;
    localparam int MSB  = XLEN - 1;

    logic [XLEN-1:0] b_inv;
    logic [XLEN:0]   acc;
    logic            lt_uns;
    logic            lt_sgn;

    assign b_inv = b ^ {XLEN{sub}};
    assign acc   = {1'b0, a} + {1'b0, b_inv} + {{XLEN{1'b0}}, sub};

    // no carry out of a - b means a borrow, so a < b unsigned
    assign lt_uns = ~acc[XLEN];
    // equal signs cannot overflow; differing signs decide directly
    assign lt_sgn = (a[MSB] ^ b[MSB]) ? a[MSB] : acc[MSB];
    assign lt     = cmp_uns ? lt_uns : lt_sgn;

    assign sum = word ? {{HALF{acc[HALF-1]}}, acc[HALF-1:0]} : acc[XLEN-1:0];

endmodule

// File: rtl/iex_shift.sv
`timescale 1ns/1ps
module iex_shift
    import iex_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    input  iex_shift_e      kind,
    input  logic            word,
    output logic [XLEN-1:0] res
);

    localparam int HALF = XLEN / 2;

    logic            is_left;
    logic            fill;
    logic [SHW-1:0]  amt_eff;
    logic [XLEN-1:0] src;
    logic [XLEN-1:0] src_rev;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] shifted_rev;
    logic [XLEN-1:0] full;
    logic [XLEN-1:0] stage [SHW+1];

    assign is_left = (kind == SH_LEFT);
    assign fill    = (kind == SH_RARI) & (word ? a[HALF-1] : a[XLEN-1]);
    assign amt_eff = word ? {1'b0, amt[SHW-2:0]} : amt;

    // word right shifts see only the low half, pre-filled above bit HALF-1
    always_comb begin
        if (word && !is_left) begin
            src = {{HALF{fill}}, a[HALF-1:0]};
        end else begin
            src = a;
        end
    end

    // left shift is a right shift of the bit-reversed operand
    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            src_rev[i]     = src[XLEN-1-i];
            shifted_rev[i] = shifted[XLEN-1-i];
        end
    end

    assign stage[0] = is_left ? src_rev : src;

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amt_eff[s]
                              ? {{STEP{fill}}, stage[s][XLEN-1:STEP]}
                              : stage[s];
        end
    endgenerate

    assign shifted = stage[SHW];
    assign full    = is_left ? shifted_rev : shifted;
    assign res     = word ? {{HALF{full[HALF-1]}}, full[HALF-1:0]} : full;

endmodule

// File: rtl/iex_logic.sv
`timescale 1ns/1ps
module iex_logic
    import iex_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  iex_logic_e      fn,
    output logic [XLEN-1:0] res
);

    always_comb begin
        unique case (fn)
            LG_OR:   res = a | b;
            LG_AND:  res = a & b;
            default: res = a ^ b;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import iex_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [OP_W-1:0] op_sel,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);

    localparam int SHW = $clog2(XLEN);

    iex_ctrl_t       ctrl;
    logic [XLEN-1:0] arith_res;
    logic            cmp_lt;
    logic [XLEN-1:0] shift_res;
    logic [XLEN-1:0] logic_res;
    logic [XLEN-1:0] next_res;

    iex_decode u_decode (
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .ctrl      (ctrl)
    );

    iex_addsub #(.XLEN(XLEN)) u_addsub (
        .a       (op_a),
        .b       (op_b),
        .sub     (ctrl.sub),
        .cmp_uns (ctrl.cmp_uns),
        .word    (ctrl.word),
        .sum     (arith_res),
        .lt      (cmp_lt)
    );

    iex_shift #(.XLEN(XLEN)) u_shift (
        .a    (op_a),
        .amt  (op_b[SHW-1:0]),
        .kind (ctrl.sh),
        .word (ctrl.word),
        .res  (shift_res)
    );

    iex_logic #(.XLEN(XLEN)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .fn  (ctrl.lg),
        .res (logic_res)
    );

    always_comb begin
        unique case (ctrl.unit)
            UNIT_ARITH: next_res = arith_res;
            UNIT_CMP:   next_res = {{(XLEN-1){1'b0}}, cmp_lt};
            UNIT_SHIFT: next_res = shift_res;
            UNIT_LOGIC: next_res = logic_res;
            default:    next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= next_res;
        end
    end

endmodule

// File: rtl/iex_checker.sv
`timescale 1ns/1ps
module iex_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic [3:0]      op_sel,
    input logic            word_mode,
    input logic [XLEN-1:0] result
);

    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // R3
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd0 && !$past(word_mode))
        |-> (result == $past(op_a) + $past(op_b)));

    // R3
    sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd1 && !$past(word_mode))
        |-> (result + $past(op_b) == $past(op_a)));

    // R6
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_mode) &&
         ($past(op_sel) == 4'd0 || $past(op_sel) == 4'd1 ||
          $past(op_sel) == 4'd2 || $past(op_sel) == 4'd6 ||
          $past(op_sel) == 4'd7))
        |-> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

    // R7
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_sel) == 4'd3 || $past(op_sel) == 4'd4))
        |-> (result[XLEN-1:1] == '0));

    // R4
    sra_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd7 && !$past(word_mode) &&
         $past(op_a[XLEN-1]) && ($past(op_b[SHW-1:0]) != '0))
        |-> result[XLEN-1]);

    // R9
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 4'd10)
        |-> (result == '0));

endmodule

bind int_exec_unit iex_checker #(.XLEN(XLEN)) u_iex_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .result    (result)
);

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  op_sel = '0;
    logic        word_mode = 1'b0;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .result    (result)
    );

    // {op, word, a, b, expected}; requirement noted per entry
    localparam int NV = 22;
    localparam logic [196:0] VEC [NV] = '{
        {4'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0},                     // R3
        {4'd1, 1'b0, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF},                     // R3
        {4'd0, 1'b1, 64'h7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000},             // R6
        {4'd1, 1'b1, 64'h1_0000_0000, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF},           // R6
        {4'd2, 1'b0, 64'h1, 64'h7F, 64'h8000_0000_0000_0000},                    // R4
        {4'd2, 1'b1, 64'h1, 64'h3F, 64'hFFFF_FFFF_8000_0000},                    // R5
        {4'd6, 1'b0, 64'h8000_0000_0000_0000, 64'h3F, 64'h1},                    // R4
        {4'd7, 1'b0, 64'h8000_0000_0000_0000, 64'h3F, 64'hFFFF_FFFF_FFFF_FFFF},  // R4
        {4'd6, 1'b0, 64'h123, 64'h40, 64'h123},                                  // R4
        {4'd6, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'h1F, 64'h1},                    // R5
        {4'd6, 1'b1, 64'hFFFF_FFFF_0000_0010, 64'h24, 64'h1},                    // R5
        {4'd7, 1'b1, 64'h8000_0000, 64'h20, 64'hFFFF_FFFF_8000_0000},            // R5
        {4'd7, 1'b1, 64'h1234_5678_8000_0000, 64'h4, 64'hFFFF_FFFF_F800_0000},   // R5
        {4'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1},                     // R7
        {4'd4, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0},                     // R7
        {4'd4, 1'b0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1},                     // R7
        {4'd5, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0}, // R8
        {4'd8, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hFFF0_FFF0_FFF0_FFF0}, // R8
        {4'd9, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000}, // R8
        {4'd3, 1'b1, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                     // R8 word ignored, R7
        {4'd12, 1'b0, 64'h5, 64'h6, 64'h0},                                      // R9
        {4'd15, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}   // R9
    };

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input logic [3:0] op, input logic w,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [31:0] lo;
        case (op)
            4'd0: return w ? sx32(32'(a[31:0] + b[31:0])) : a + b;
            4'd1: return w ? sx32(32'(a[31:0] - b[31:0])) : a - b;
            4'd2: return w ? sx32(32'(a[31:0] << b[4:0])) : a << b[5:0];
            4'd3: return {63'd0, $signed(a) < $signed(b)};
            4'd4: return {63'd0, a < b};
            4'd5: return a ^ b;
            4'd6: return w ? sx32(32'(a[31:0] >> b[4:0])) : a >> b[5:0];
            4'd7: begin
                if (w) begin
                    lo = 32'($signed(a[31:0]) >>> b[4:0]);
                    return sx32(lo);
                end
                return 64'($signed(a) >>> b[5:0]);
            end
            4'd8: return a | b;
            4'd9: return a & b;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic w,
                          input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] got);
        @(negedge clk);
        op_sel    = op;
        word_mode = w;
        op_a      = a;
        op_b      = b;
        @(negedge clk);
        got = result;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [3:0]  vop;
        logic        vw;
        logic [63:0] va, vb, ve;

        // R1: result held at zero during reset despite active inputs
        op_sel = 4'd0; op_a = 64'd5; op_b = 64'd6;
        repeat (3) @(negedge clk);
        check("R1 reset clear", result, 64'd0);
        rst_n = 1'b1;

        // R2: output changes only at the next edge
        run_op(4'd0, 1'b0, 64'd1, 64'd2, got);
        check("R2 first result", got, 64'd3);
        @(negedge clk);
        op_a = 64'd10; op_b = 64'd20;
        #1;
        check("R2 held before edge", result, 64'd3);
        @(negedge clk);
        check("R2 updated after edge", result, 64'd30);

        for (int i = 0; i < NV; i++) begin
            {vop, vw, va, vb, ve} = VEC[i];
            run_op(vop, vw, va, vb, got);
            check($sformatf("vector %0d op %0d word %0d (R3..R9 as tagged)", i, vop, vw), got, ve);
        end

        // R4 R5 R6: shift amounts 0, 31, 32, 63 for every shift form
        for (int k = 0; k < 4; k++) begin
            logic [63:0] amt;
            amt = (k == 0) ? 64'd0 : (k == 1) ? 64'd31 : (k == 2) ? 64'd32 : 64'd63;
            for (int s = 0; s < 3; s++) begin
                logic [3:0] sop;
                sop = (s == 0) ? 4'd2 : (s == 1) ? 4'd6 : 4'd7;
                for (int w = 0; w < 2; w++) begin
                    va = {$urandom(), $urandom()} | 64'h8000_0000_8000_0000;
                    run_op(sop, w[0], va, amt, got);
                    check($sformatf("R4/R5 shift op %0d word %0d amt %0d", sop, w, amt),
                          got, model(sop, w[0], va, amt));
                end
            end
        end

        // R3 R6 R7 R8: random operands over all defined codes
        for (int i = 0; i < 400; i++) begin
            vop = 4'($urandom_range(0, 9));
            vw  = 1'($urandom());
            va  = {$urandom(), $urandom()};
            vb  = {$urandom(), $urandom()};
            if (i % 4 == 0) vb = va;
            run_op(vop, vw, va, vb, got);
            check($sformatf("R6 random op %0d word %0d", vop, vw), got, model(vop, vw, va, vb));
        end

        // R1: reset mid-run clears a non-zero result
        run_op(4'd8, 1'b0, 64'hFF, 64'h0, got);
        check("R8 before reset", got, 64'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", result, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule